// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider for a PLL

This block divides the oscillator clock of a phase-locked loop down to the comparison rate and hands the phase detector one pulse for every N oscillator cycles. A prescaler stage runs either with a fixed ratio (1, 2 or 3) or as a dual-modulus stage (P/P+1 with P of 2, 4, 8, 16 or 32). A swallow count A and a main count B steer it, so the total ratio is N = P·B + A in dual-modulus mode and N = P·B with a fixed ratio.

In dual-modulus mode the prescaler runs at P+1 for the first A of the B prescaler periods and at P for the rest. A bypass bit forces B to one when a fixed ratio is selected, so ratios down to one are possible. The ratio inputs are sampled only when a count window ends (or when the counters are restarted), so software may rewrite them at any time without making a short or long window. A synchronous clear input restarts the count.

Top module: `fbdiv_feedback`

## Requirements
- R1: While rst_ni is low fb_pulse_o is 0; the first clock edge with rst_ni high loads the ratio inputs, and the first pulse comes exactly N edges after that edge.
- R2: mode_i values 0, 1 and 2 select a fixed prescaler ratio of 1, 2 and 3; then N = P·B and a_cnt_i has no effect.
- R3: mode_i values 3, 4, 5, 6 and 7 select dual-modulus P/P+1 with P = 2, 4, 8, 16 and 32; then N = P·B + A.
- R4: In dual-modulus mode an A larger than the effective B is taken as equal to B, giving N = (P+1)·B.
- R5: A b_cnt_i of 0 is taken as 1.
- R6: b_bypass_i high with a fixed ratio makes B equal to 1 (so N = P, and N = 1 gives a pulse on every cycle); in dual-modulus mode b_bypass_i has no effect.
- R7: fb_pulse_o is high for exactly one clock cycle per window whenever N is 2 or more, and successive pulses are exactly N cycles apart.
- R8: Changes of mode_i, a_cnt_i, b_cnt_i or b_bypass_i during a window do not alter that window; the new ratio applies from the window that starts at the next pulse.
- R9: cnt_clr_i sampled high at an edge restarts the count from the current inputs: no pulse at that edge, and the next pulse comes N edges later.
- R10: b_cnt_i accepts every value up to 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | Oscillator clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Prescaler mode code (see R2, R3) |
| a_cnt_i | input | A_W (6) | Swallow count A |
| b_cnt_i | input | B_W (13) | Main count B |
| b_bypass_i | input | 1 | Force B to one in fixed-ratio modes |
| cnt_clr_i | input | 1 | Synchronous counter restart |
| fb_pulse_o | output | 1 | One-cycle pulse per N input cycles |

## Verification
The assertions watch every cycle for a pulse that lasts more than one cycle when the window is longer than one, for a pulse on a restart edge, for the swallow count ever exceeding the main count still to run, for the prescaler count going beyond its modulus, and for the latched ratio changing anywhere but at a window boundary. The exact ratio for each mode code, the clamping of A and B, the bypass behaviour and the deferral of new settings can only be shown by the bench's scenarios, which compare the pulse position on every edge with the ratio computed from the requirements.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int MODE_W = 3;
    localparam int MAX_P  = 32;
    localparam int PRE_W  = $clog2(MAX_P + 1);

    typedef enum logic [MODE_W-1:0] {
        PS_FIX1   = 3'd0,
        PS_FIX2   = 3'd1,
        PS_FIX3   = 3'd2,
        PS_DUAL2  = 3'd3,
        PS_DUAL4  = 3'd4,
        PS_DUAL8  = 3'd5,
        PS_DUAL16 = 3'd6,
        PS_DUAL32 = 3'd7
    } ps_mode_e;

    // Base modulus P of the prescaler for a mode code.
    function automatic logic [PRE_W-1:0] base_modulus(input ps_mode_e m);
        case (m)
            PS_FIX1:   return PRE_W'(1);
            PS_FIX2:   return PRE_W'(2);
            PS_FIX3:   return PRE_W'(3);
            PS_DUAL2:  return PRE_W'(2);
            PS_DUAL4:  return PRE_W'(4);
            PS_DUAL8:  return PRE_W'(8);
            PS_DUAL16: return PRE_W'(16);
            default:   return PRE_W'(32);
        endcase
    endfunction

    function automatic logic is_dual(input ps_mode_e m);
        return (m >= PS_DUAL2);
    endfunction

endpackage

// File: rtl/fbdiv_decode.sv
module fbdiv_decode
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [A_W-1:0]    a_i,
    input  logic [B_W-1:0]    b_i,
    input  logic              bypass_i,
    output logic [PRE_W-1:0]  p_o,
    output logic              dual_o,
    output logic [A_W-1:0]    a_eff_o,
    output logic [B_W-1:0]    b_eff_o,
    output logic              unit_o
);

    ps_mode_e          mode_w;
    logic [B_W-1:0]    a_wide;
    logic [B_W-1:0]    a_clamp;

    always_comb begin
        mode_w = ps_mode_e'(mode_i);
        p_o    = base_modulus(mode_w);
        dual_o = is_dual(mode_w);

        // B: bypass only in fixed modes, zero reads as one
        if (bypass_i && !dual_o) begin
            b_eff_o = B_W'(1);
        end else if (b_i == '0) begin
            b_eff_o = B_W'(1);
        end else begin
            b_eff_o = b_i;
        end

        // A: unused in fixed modes, never above B in dual modes
        a_wide  = B_W'(a_i);
        a_clamp = (a_wide > b_eff_o) ? b_eff_o : a_wide;
        a_eff_o = dual_o ? A_W'(a_clamp) : '0;

        unit_o  = !dual_o && (p_o == PRE_W'(1)) && (b_eff_o == B_W'(1));
    end

endmodule

// File: rtl/fbdiv_core.sv
module fbdiv_core
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] p_i,
    input  logic             dual_i,
    input  logic [A_W-1:0]   a_eff_i,
    input  logic [B_W-1:0]   b_eff_i,
    input  logic             unit_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;      // input cycles left in this prescaler period, minus one
        logic [A_W-1:0]   a_rem;    // prescaler periods still to run at P+1
        logic [B_W-1:0]   b_rem;    // prescaler periods left after this one
        logic [PRE_W-1:0] p;        // latched base modulus
        logic             dual;     // latched dual-modulus flag
        logic             unit;     // latched window length of one
        logic             pulse;
        logic             restart;
    } state_t;

    state_t st_d, st_q;
    logic   load_w;
    logic   pre_end_w;
    logic   win_end_w;
    logic [A_W-1:0] a_next_w;

    always_comb begin
        st_d      = st_q;
        st_d.pulse   = 1'b0;
        st_d.restart = 1'b0;
        pre_end_w = (st_q.pre == '0);
        win_end_w = pre_end_w && (st_q.b_rem == '0);
        load_w    = st_q.restart || clr_i || win_end_w;
        a_next_w  = st_q.a_rem - A_W'(st_q.a_rem != '0);

        if (load_w) begin
            st_d.p     = p_i;
            st_d.dual  = dual_i;
            st_d.unit  = unit_i;
            st_d.a_rem = a_eff_i;
            st_d.b_rem = b_eff_i - B_W'(1);
            st_d.pre   = (dual_i && (a_eff_i != '0)) ? p_i : (p_i - PRE_W'(1));
            st_d.pulse = win_end_w && !st_q.restart && !clr_i;
        end else if (!pre_end_w) begin
            st_d.pre = st_q.pre - PRE_W'(1);
        end else begin
            st_d.b_rem = st_q.b_rem - B_W'(1);
            st_d.a_rem = a_next_w;
            st_d.pre   = (st_q.dual && (a_next_w != '0)) ? st_q.p : (st_q.p - PRE_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.restart <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    // R7
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pulse && !st_q.unit && !clr_i) |=> !st_q.pulse);

    // R9
    clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !st_q.pulse);

    // R4
    a_within_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (B_W+1)'(st_q.a_rem) <= ((B_W+1)'(st_q.b_rem) + (B_W+1)'(1)));

    // R3
    pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pre <= st_q.p);

    // R8
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_w |=> ($stable(st_q.p) && $stable(st_q.dual)));

    // R5
    b_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_w |-> (b_eff_i != '0));

endmodule

// File: rtl/fbdiv_feedback.sv
module fbdiv_feedback
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic              clk_vco_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [A_W-1:0]    a_cnt_i,
    input  logic [B_W-1:0]    b_cnt_i,
    input  logic              b_bypass_i,
    input  logic              cnt_clr_i,
    output logic              fb_pulse_o
);

    logic [PRE_W-1:0] p_w;
    logic             dual_w;
    logic [A_W-1:0]   a_eff_w;
    logic [B_W-1:0]   b_eff_w;
    logic             unit_w;

    fbdiv_decode #(.A_W(A_W), .B_W(B_W)) i_decode (
        .mode_i   (mode_i),
        .a_i      (a_cnt_i),
        .b_i      (b_cnt_i),
        .bypass_i (b_bypass_i),
        .p_o      (p_w),
        .dual_o   (dual_w),
        .a_eff_o  (a_eff_w),
        .b_eff_o  (b_eff_w),
        .unit_o   (unit_w)
    );

    fbdiv_core #(.A_W(A_W), .B_W(B_W)) i_core (
        .clk_i   (clk_vco_i),
        .rst_ni  (rst_ni),
        .clr_i   (cnt_clr_i),
        .p_i     (p_w),
        .dual_i  (dual_w),
        .a_eff_i (a_eff_w),
        .b_eff_i (b_eff_w),
        .unit_i  (unit_w),
        .pulse_o (fb_pulse_o)
    );

endmodule

// File: tb/test_fbdiv_feedback.sv
module test_fbdiv_feedback;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [5:0]  a_cnt = '0;
    logic [12:0] b_cnt = '0;
    logic        byp = 1'b0;
    logic        clr = 1'b0;
    logic        fb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [2:0]  m2;
    logic [5:0]  a2;
    logic [12:0] b2;
    logic        y2;

    always #2.5 clk = ~clk;

    fbdiv_feedback i_fbdiv_feedback (
        .clk_vco_i  (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .a_cnt_i    (a_cnt),
        .b_cnt_i    (b_cnt),
        .b_bypass_i (byp),
        .cnt_clr_i  (clr),
        .fb_pulse_o (fb)
    );

    // Ratio from the requirements (R2..R6).
    function automatic int nref(input int m, input int a, input int b, input bit y);
        int p; bit dual; int be; int ae;
        case (m)
            0: p = 1;  1: p = 2;  2: p = 3;  3: p = 2;
            4: p = 4;  5: p = 8;  6: p = 16; default: p = 32;
        endcase
        dual = (m >= 3);
        be = (y && !dual) ? 1 : ((b == 0) ? 1 : b);
        ae = dual ? ((a > be) ? be : a) : 0;
        return p * be + ae;
    endfunction

    // Called at the falling edge just after the start edge (k = 0).
    task automatic observe(input string tag, input int n1, input int n2,
                           input int chg_k, input int total);
        int bad = 0; int fk = -1; logic fa = 1'b0; logic fe = 1'b0;
        for (int k = 0; k <= total; k++) begin
            logic exp_v;
            if (k > 0) @(negedge clk);
            exp_v = (k > 0) && ((k <= n1) ? (k == n1) : (((k - n1) % n2) == 0));
            if (fb !== exp_v) begin
                if (bad == 0) begin fk = k; fa = fb; fe = exp_v; end
                bad++;
            end
            if (k == chg_k) begin
                mode = m2; a_cnt = a2; b_cnt = b2; byp = y2;
            end
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s: edge %0d after start pulse=%b expected %b (%0d mismatches, N=%0d/%0d)",
                     tag, fk, fa, fe, bad, n1, n2);
        end
    endtask

    task automatic start(input int m, input int a, input int b, input bit y);
        mode = 3'(m); a_cnt = 6'(a); b_cnt = 13'(b); byp = y; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic plain(input string tag, input int m, input int a, input int b,
                         input bit y, input int windows);
        int n = nref(m, a, b, y);
        start(m, a, b, y);
        observe(tag, n, n, -1, windows * n + 1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20517);

        // R1: reset state, then first window after release
        mode = 3'd1; b_cnt = 13'd3; a_cnt = 6'd9; byp = 1'b0;
        begin
            int bad = 0;
            repeat (4) begin
                @(negedge clk);
                if (fb !== 1'b0) bad++;
            end
            checks++;
            if (bad != 0) begin
                failures++;
                $display("FAIL R1: pulse during reset actual=%b expected 0", fb);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        observe("R1", 6, 6, -1, 13);

        // R2: fixed ratios, A has no effect
        plain("R2 fix3 A ignored", 2, 17, 5, 1'b0, 2);
        plain("R2 fix2", 1, 0, 9, 1'b0, 2);
        plain("R2 fix1", 0, 63, 4, 1'b0, 3);

        // R3: dual-modulus ratios
        plain("R3 dual2", 3, 1, 4, 1'b0, 2);
        plain("R3 dual32", 7, 5, 7, 1'b0, 2);
        plain("R3 dual8 A=0", 5, 0, 3, 1'b0, 2);

        // R4: A above B is clamped
        plain("R4 clamp", 4, 40, 6, 1'b0, 2);

        // R5: B of zero reads as one
        plain("R5 dual16 B=0", 6, 3, 0, 1'b0, 3);
        plain("R5 fix3 B=0", 2, 0, 0, 1'b0, 3);

        // R6: bypass
        plain("R6 fix1 bypass N=1", 0, 7, 100, 1'b1, 12);
        plain("R6 fix3 bypass", 2, 0, 20, 1'b1, 4);
        plain("R6 dual4 bypass ignored", 4, 2, 5, 1'b1, 2);

        // R10: largest B
        plain("R10 B=8191", 0, 0, 8191, 1'b0, 2);

        // R8: settings changed mid-window take effect at the next window
        m2 = 3'd3; a2 = 6'd1; b2 = 13'd3; y2 = 1'b0;
        start(1, 0, 10, 1'b0);
        observe("R8 deferred load", 20, nref(3, 1, 3, 1'b0), 5, 20 + 2 * 7 + 1);

        // R9: clear in the middle of a window restarts the count
        start(1, 0, 5, 1'b0);
        observe("R9 before clear", 10, 10, -1, 4);
        start(1, 0, 5, 1'b0);
        observe("R9 after clear", 10, 10, -1, 21);

        // R7: random ratios, some with a mid-window change
        for (int i = 0; i < 30; i++) begin
            int m1 = int'($urandom % 8);
            int a1 = int'($urandom % 64);
            int b1 = int'($urandom % 48);
            bit yy = (($urandom % 4) == 0);
            int n1 = nref(m1, a1, b1, yy);
            if ((i % 3) == 2) begin
                int n2;
                m2 = 3'($urandom % 8); a2 = 6'($urandom % 64);
                b2 = 13'($urandom % 48); y2 = (($urandom % 4) == 0);
                n2 = nref(int'(m2), int'(a2), int'(b2), y2);
                start(m1, a1, b1, yy);
                observe("R7/R8 random change", n1, n2, int'($urandom % n1), n1 + 2 * n2 + 1);
            end else begin
                plain("R7 random period", m1, a1, b1, yy, 2);
            end
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule